// File: doc/BRIEF.md
# PLL Divider and Lock Detector

This block is the digital half of a clock-generation PLL. It forms the PLL reference from either the oscillator (divided by a programmable ratio) or an internal reference source. It divides the VCO clock down to a feedback rate and judges lock by comparing frequencies: it counts feedback periods over a window of 64 reference periods and compares the count with 64. It also divides the VCO clock by a programmable post ratio to give the PLL output clock enable. The phase detector, loop filter and VCO are analog and are not part of this block.

The control side runs on the system clock `clk`. The oscillator and the internal reference arrive as single-cycle tick enables in the `clk` domain. The VCO clock is a true clock of its own. Feedback periods are counted in the VCO domain in Gray code and synchronized into `clk`. Lock is reported on a read-only status bit. Every change of that bit, in either direction, sets a sticky event flag. When the enable is set, the flag drives the interrupt output.

Software can poll `lockStat` or wait for `lockIrq`. The output clock counts as stable only while `lockStat` is 1. All divider fields hold N-1 for a ratio of N.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset `lockStat`, `lockFlag` and `lockIrq` are 0 and every divider ratio is 1, so `pllClkEn` is high on every VCO cycle.
- R2: With `cfgRefSel`=0 the reference ticks once per (`cfgRefDiv`+1) `oscTick` pulses. With `cfgRefSel`=1 each `ircTick` is a reference tick and `oscTick` is ignored.
- R3: The feedback rate is the VCO clock divided by (`cfgSynDiv`+1). The feedback period count over each 64-period reference window is compared with 64, so a wrong ratio never locks.
- R4: While unlocked, `lockStat` rises only after two consecutive windows whose count differs from 64 by at most 2. It stays 0 after one such window.
- R5: While locked, a window whose count differs from 64 by 3 or 4 keeps the lock. A window that differs by more than 4 clears it.
- R6: Every change of `lockStat`, whether rising or falling, sets `lockFlag` in the same cycle that `lockStat` changes.
- R7: `lockFlag` is sticky and is cleared only by a `lockFlagClr` pulse. A change of lock in the same cycle wins over the clear.
- R8: `lockIrq` is `lockFlag` AND `lockIe`.
- R9: A `cfgWrDiv` pulse loads the reference divider, the feedback divider and the source select. It clears `lockStat` in the next cycle and restarts the window. A `cfgWrPost` pulse does not disturb the lock.
- R10: `pllClkEn` is high for one VCO cycle in every (`cfgPostDiv`+1) VCO cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the control and lock logic |
| rstN | input | 1 | Active-low asynchronous reset |
| oscTick | input | 1 | Oscillator tick enable in the clk domain |
| ircTick | input | 1 | Internal reference tick enable in the clk domain |
| vcoClk | input | 1 | VCO clock |
| cfgWrDiv | input | 1 | Write strobe for the reference and feedback dividers and the source select |
| cfgSynDiv | input | 6 | Feedback divider field, ratio = value+1 |
| cfgRefDiv | input | 4 | Reference divider field, ratio = value+1 |
| cfgRefSel | input | 1 | Reference source: 0 divided oscillator, 1 internal reference |
| cfgWrPost | input | 1 | Write strobe for the post divider |
| cfgPostDiv | input | 5 | Post divider field, ratio = value+1 |
| lockIe | input | 1 | Lock interrupt enable |
| lockFlagClr | input | 1 | Write-one-to-clear pulse for the lock event flag |
| lockStat | output | 1 | Read-only lock status |
| lockFlag | output | 1 | Sticky lock change flag |
| lockIrq | output | 1 | Lock interrupt request |
| pllClkEn | output | 1 | PLL output clock enable in the VCO domain |

## Verification
The assertions assume that `cfgWrDiv`, `cfgWrPost` and `lockFlagClr` are single-cycle pulses that are synchronous to `clk`. They also assume that the divider fields change only together with their write strobe. The stimulus meets this by driving every input on the falling edge of `clk` from tasks. It holds each field steady around its strobe and gives the VCO clock a phase that never coincides with `clk` edges. The Gray-coded feedback count crosses into `clk` safely only if `clk` samples it faster than it advances. The bench therefore keeps the feedback rate at or below the `clk` rate.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // reload config, clear window state
  } ctrlStrobe_t;

  // window result from datapath to control
  typedef struct packed {
    logic winDone;   // a comparison window just ended
    logic inTight;   // count within the acquire tolerance
    logic outLoose;  // count beyond the hold tolerance
  } winStatus_t;

endpackage

// File: rtl/pll_lock_datapath.sv
module pll_lock_datapath
  import pll_lock_pkg::*;
#(
  parameter int SYN_W   = 6,
  parameter int REF_W   = 4,
  parameter int CNT_W   = 10,
  parameter int WIN_LOG = 6,
  parameter int TIGHT   = 2,
  parameter int LOOSE   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vcoClk,
  input  logic             vcoRstN,
  input  logic             oscTick,
  input  logic             ircTick,
  input  logic [SYN_W-1:0] cfgSynDiv,
  input  logic [REF_W-1:0] cfgRefDiv,
  input  logic             cfgRefSel,
  input  ctrlStrobe_t      strobe,
  output winStatus_t       status
);

  localparam int WIN = 1 << WIN_LOG;
  localparam logic [CNT_W-1:0] WIN_C   = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] TIGHT_C = CNT_W'(TIGHT);
  localparam logic [CNT_W-1:0] LOOSE_C = CNT_W'(LOOSE);

  // configuration registers (clk domain)
  logic [SYN_W-1:0] synDivQ;
  logic [REF_W-1:0] refDivQ;
  logic             refSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synDivQ <= '0;
      refDivQ <= '0;
      refSelQ <= 1'b0;
    end else if (strobe.restart) begin
      synDivQ <= cfgSynDiv;
      refDivQ <= cfgRefDiv;
      refSelQ <= cfgRefSel;
    end
  end

  // reference divider
  logic [REF_W-1:0] refCnt;
  logic             oscWrap;
  logic             refTick;

  assign oscWrap = oscTick && (refCnt >= refDivQ);
  assign refTick = refSelQ ? ircTick : oscWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               refCnt <= '0;
    else if (strobe.restart) refCnt <= '0;
    else if (oscTick)        refCnt <= oscWrap ? '0 : refCnt + 1'b1;
  end

  // feedback divider and Gray period counter (VCO domain)
  // synDivQ is quasi-static: it changes only on a restart, which discards the window
  logic [SYN_W-1:0] fbDivCnt;
  logic [CNT_W-1:0] fbBin, fbBinNext, fbGray;

  assign fbBinNext = fbBin + 1'b1;

  always_ff @(posedge vcoClk or negedge vcoRstN) begin
    if (!vcoRstN) begin
      fbDivCnt <= '0;
      fbBin    <= '0;
      fbGray   <= '0;
    end else if (fbDivCnt >= synDivQ) begin
      fbDivCnt <= '0;
      fbBin    <= fbBinNext;
      fbGray   <= fbBinNext ^ (fbBinNext >> 1);
    end else begin
      fbDivCnt <= fbDivCnt + 1'b1;
    end
  end

  // synchronize the Gray count into clk
  logic [CNT_W-1:0] graySync1, graySync2, fbSyncBin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graySync1 <= '0;
      graySync2 <= '0;
    end else begin
      graySync1 <= fbGray;
      graySync2 <= graySync1;
    end
  end

  always_comb begin
    fbSyncBin[CNT_W-1] = graySync2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      fbSyncBin[i] = fbSyncBin[i+1] ^ graySync2[i];
    end
  end

  // window timing and baseline capture
  logic [WIN_LOG-1:0] winCnt;
  logic [CNT_W-1:0]   baseQ;
  logic               winEnd;

  assign winEnd = refTick && (winCnt == WIN_LOG'(WIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      baseQ  <= '0;
    end else if (strobe.restart) begin
      winCnt <= '0;
      baseQ  <= fbSyncBin;
    end else if (refTick) begin
      winCnt <= winCnt + 1'b1;
      if (winEnd) baseQ <= fbSyncBin;
    end
  end

  // count deviation from the window length
  logic [CNT_W-1:0] delta, diff;

  always_comb begin
    delta = fbSyncBin - baseQ;
    diff  = (delta >= WIN_C) ? (delta - WIN_C) : (WIN_C - delta);
  end

  assign status.winDone  = winEnd && !strobe.restart;
  assign status.inTight  = diff <= TIGHT_C;
  assign status.outLoose = diff > LOOSE_C;

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_pkg::*;
#(
  parameter int PASS_NEED = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrDiv,
  input  logic        lockIe,
  input  logic        lockFlagClr,
  input  winStatus_t  status,
  output ctrlStrobe_t strobe,
  output logic        lockStat,
  output logic        lockFlag,
  output logic        lockIrq
);

  localparam int STREAK_W = $clog2(PASS_NEED + 1);

  logic [STREAK_W-1:0] streakQ, streakNext;
  logic                lockQ, lockNext, flagQ;

  assign strobe.restart = cfgWrDiv;

  always_comb begin
    lockNext   = lockQ;
    streakNext = streakQ;
    if (cfgWrDiv) begin
      lockNext   = 1'b0;
      streakNext = '0;
    end else if (status.winDone) begin
      if (lockQ) begin
        if (status.outLoose) lockNext = 1'b0;
      end else if (status.inTight) begin
        if (streakQ == STREAK_W'(PASS_NEED - 1)) begin
          lockNext   = 1'b1;
          streakNext = '0;
        end else begin
          streakNext = streakQ + 1'b1;
        end
      end else begin
        streakNext = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ   <= 1'b0;
      streakQ <= '0;
      flagQ   <= 1'b0;
    end else begin
      lockQ   <= lockNext;
      streakQ <= streakNext;
      if (lockNext != lockQ) flagQ <= 1'b1;
      else if (lockFlagClr)  flagQ <= 1'b0;
    end
  end

  assign lockStat = lockQ;
  assign lockFlag = flagQ;
  assign lockIrq  = flagQ & lockIe;

endmodule

// File: rtl/pll_post_div.sv
module pll_post_div #(
  parameter int POST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoClk,
  input  logic              vcoRstN,
  input  logic              cfgWrPost,
  input  logic [POST_W-1:0] cfgPostDiv,
  output logic              pllClkEn
);

  logic [POST_W-1:0] postDivQ;
  logic [POST_W-1:0] postCnt;
  logic              postWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          postDivQ <= '0;
    else if (cfgWrPost) postDivQ <= cfgPostDiv;
  end

  // quasi-static ratio used in the VCO domain
  assign postWrap = postCnt >= postDivQ;

  always_ff @(posedge vcoClk or negedge vcoRstN) begin
    if (!vcoRstN)     postCnt <= '0;
    else if (postWrap) postCnt <= '0;
    else               postCnt <= postCnt + 1'b1;
  end

  assign pllClkEn = postWrap;

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_pkg::*;
#(
  parameter int SYN_W     = 6,
  parameter int REF_W     = 4,
  parameter int POST_W    = 5,
  parameter int CNT_W     = 10,
  parameter int WIN_LOG   = 6,
  parameter int TIGHT     = 2,
  parameter int LOOSE     = 4,
  parameter int PASS_NEED = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              ircTick,
  input  logic              vcoClk,
  input  logic              cfgWrDiv,
  input  logic [SYN_W-1:0]  cfgSynDiv,
  input  logic [REF_W-1:0]  cfgRefDiv,
  input  logic              cfgRefSel,
  input  logic              cfgWrPost,
  input  logic [POST_W-1:0] cfgPostDiv,
  input  logic              lockIe,
  input  logic              lockFlagClr,
  output logic              lockStat,
  output logic              lockFlag,
  output logic              lockIrq,
  output logic              pllClkEn
);

  ctrlStrobe_t strobe;
  winStatus_t  status;

  // reset synchronizer for the VCO domain
  logic [1:0] vcoRstSync;
  logic       vcoRstN;

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) vcoRstSync <= 2'b00;
    else       vcoRstSync <= {vcoRstSync[0], 1'b1};
  end
  assign vcoRstN = vcoRstSync[1];

  pll_lock_datapath #(
    .SYN_W(SYN_W), .REF_W(REF_W), .CNT_W(CNT_W),
    .WIN_LOG(WIN_LOG), .TIGHT(TIGHT), .LOOSE(LOOSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .vcoClk(vcoClk), .vcoRstN(vcoRstN),
    .oscTick(oscTick), .ircTick(ircTick),
    .cfgSynDiv(cfgSynDiv), .cfgRefDiv(cfgRefDiv), .cfgRefSel(cfgRefSel),
    .strobe(strobe), .status(status)
  );

  pll_lock_ctrl #(.PASS_NEED(PASS_NEED)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrDiv(cfgWrDiv), .lockIe(lockIe),
    .lockFlagClr(lockFlagClr), .status(status), .strobe(strobe),
    .lockStat(lockStat), .lockFlag(lockFlag), .lockIrq(lockIrq)
  );

  pll_post_div #(.POST_W(POST_W)) u_post (
    .clk(clk), .rstN(rstN), .vcoClk(vcoClk), .vcoRstN(vcoRstN),
    .cfgWrPost(cfgWrPost), .cfgPostDiv(cfgPostDiv), .pllClkEn(pllClkEn)
  );

endmodule

// File: rtl/pll_lock_checker.sv
module pll_lock_checker (
  input logic clk,
  input logic rstN,
  input logic cfgWrDiv,
  input logic cfgWrPost,
  input logic lockIe,
  input logic lockFlagClr,
  input logic lockStat,
  input logic lockFlag,
  input logic lockIrq
);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockIrq |-> (lockIe && lockFlag));

  assert_change_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lockStat != $past(lockStat)) |-> lockFlag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && !lockFlagClr) |=> lockFlag);

  assert_write_drops_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrDiv |=> !lockStat);

  assert_no_rise_after_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStat) |-> !$past(cfgWrDiv));

  assert_post_write_keeps_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrPost && !cfgWrDiv && lockStat) |=> (lockStat || lockFlag));

endmodule

bind pll_lock_detect pll_lock_checker u_chk (.*);

// File: tb/test_pll_lock_detect.sv
`timescale 1ns/1ps
module test_pll_lock_detect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b1;
  logic       ircTick = 1'b0;
  logic       vcoClk = 1'b0;
  logic       cfgWrDiv = 1'b0;
  logic [5:0] cfgSynDiv = '0;
  logic [3:0] cfgRefDiv = '0;
  logic       cfgRefSel = 1'b0;
  logic       cfgWrPost = 1'b0;
  logic [4:0] cfgPostDiv = '0;
  logic       lockIe = 1'b0;
  logic       lockFlagClr = 1'b0;
  logic       lockStat, lockFlag, lockIrq, pllClkEn;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  real vcoHalf = 10.0;
  int  ircDiv = 0;

  localparam int WINDOW = 256; // clk cycles per window at an 80 ns reference

  pll_lock_detect i_pll_lock_detect (.*);

  always #10 clk = ~clk;

  initial begin
    #3.3;
    forever #(vcoHalf) vcoClk = ~vcoClk;
  end

  // internal reference: one tick every 4 clk cycles
  always @(negedge clk) begin
    ircDiv  = (ircDiv + 1) % 4;
    ircTick <= (ircDiv == 0);
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeDiv(int refDiv, int synDiv, bit sel);
    @(negedge clk);
    cfgRefDiv = 4'(refDiv); cfgSynDiv = 6'(synDiv); cfgRefSel = sel; cfgWrDiv = 1'b1;
    @(negedge clk);
    cfgWrDiv = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); lockFlagClr = 1'b1;
    @(negedge clk); lockFlagClr = 1'b0;
  endtask

  task automatic countPulses(int n, output int cnt);
    cnt = 0;
    @(negedge vcoClk);
    repeat (n) begin
      @(negedge vcoClk);
      if (pllClkEn) cnt++;
    end
  endtask

  task automatic testReset();
    int c;
    check("R1 lockStat after reset", lockStat, 0);
    check("R1 lockFlag after reset", lockFlag, 0);
    check("R1 lockIrq after reset", lockIrq, 0);
    countPulses(10, c);
    check("R1 output enable every VCO cycle", c, 10);
  endtask

  task automatic testAcquire();
    writeDiv(3, 3, 1'b0);
    clearFlag();
    waitClk(WINDOW + WINDOW / 2 - 2);
    check("R4 no lock after one window", lockStat, 0);
    waitClk(WINDOW);
    check("R4 lock after two windows", lockStat, 1);
    check("R6 flag on lock rise", lockFlag, 1);
    check("R8 irq masked when disabled", lockIrq, 0);
    @(negedge clk); lockIe = 1'b1;
    @(negedge clk);
    check("R8 irq when enabled", lockIrq, 1);
    clearFlag();
    check("R7 flag cleared by clear pulse", lockFlag, 0);
    check("R8 irq drops with flag", lockIrq, 0);
  endtask

  task automatic testPost();
    int c;
    @(negedge clk); cfgPostDiv = 5'd2; cfgWrPost = 1'b1;
    @(negedge clk); cfgWrPost = 1'b0;
    waitClk(4);
    check("R9 post write keeps lock", lockStat, 1);
    check("R9 post write no flag", lockFlag, 0);
    countPulses(30, c);
    check("R10 post divide by 3", c, 10);
  endtask

  task automatic testHysteresis();
    vcoHalf = 10.4;
    waitClk(3 * WINDOW);
    check("R5 small drift keeps lock", lockStat, 1);
    check("R5 small drift no flag", lockFlag, 0);
  endtask

  task automatic testDrift();
    vcoHalf = 12.0;
    waitClk(3 * WINDOW);
    check("R5 large drift clears lock", lockStat, 0);
    check("R6 flag on lock fall", lockFlag, 1);
    check("R8 irq on lock fall", lockIrq, 1);
    vcoHalf = 10.0;
    clearFlag();
    waitClk(4 * WINDOW);
    check("R4 relock after recovery", lockStat, 1);
  endtask

  task automatic testWriteClears();
    clearFlag();
    writeDiv(3, 3, 1'b0);
    check("R9 divider write clears lock", lockStat, 0);
    check("R6 flag on write-induced clear", lockFlag, 1);
  endtask

  task automatic testRatio();
    writeDiv(3, 1, 1'b0);
    waitClk(4 * WINDOW);
    check("R3 wrong feedback ratio never locks", lockStat, 0);
  endtask

  task automatic testRefSel();
    writeDiv(0, 3, 1'b1);
    waitClk(4 * WINDOW);
    check("R2 internal reference locks", lockStat, 1);
    writeDiv(0, 3, 1'b0);
    waitClk(4 * WINDOW);
    check("R2 undivided oscillator does not lock", lockStat, 0);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testAcquire();
    testPost();
    testHysteresis();
    testDrift();
    testWriteClears();
    testRatio();
    testRefSel();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule